// File: doc/BRIEF.md
# Not-Recently-Used Page Victim Selector

This block keeps two status bits for every physical page frame: a used bit, set whenever the frame is touched, and a dirty bit, set when the touch is a store. From the two bits each frame falls into one of four classes, and when the replacement logic asks for a frame to evict, the block answers with a frame from the lowest class that currently holds any frame. A periodic sweep pulse clears all used bits, so "used" means "touched since the last sweep", while dirty bits survive until the frame is refilled.

Inside the winning class the choice is pseudo-random: a 16-bit maximal-length shift register advances on every clock, its value reduced modulo the frame count gives a start position, and the block takes the first frame of the winning class found by walking upward from there with wraparound. A small two-state machine offers the chosen frame until the requester acknowledges it. Once the new page has been brought in, a fill strobe marks that frame as just used and clean.

Top module: `nru_victim_sel`

The controller has two states. `ST_WAIT_REQ` (after reset) moves to `ST_OFFER` on a cycle with `victim_req` high, capturing the victim at that edge. `ST_OFFER` drives `victim_valid` and returns to `ST_WAIT_REQ` on a cycle with `victim_ack` high.

## Requirements
- R1: Reset clears every used and dirty bit, drops `victim_valid` and places the controller in `ST_WAIT_REQ`.
- R2: A touch (`ref_valid`) sets the used bit of frame `ref_idx`; when `ref_write` is 1 it also sets that frame's dirty bit, and a read touch leaves the dirty bit as it was.
- R3: A frame's class is 2*used + dirty: 0 unused and clean, 1 unused and dirty, 2 used and clean, 3 used and dirty.
- R4: A `clear_tick` cycle clears the used bit of every frame and leaves every dirty bit unchanged.
- R5: When a touch and `clear_tick` fall in the same cycle, the touched frame's used bit ends at 1.
- R6: The offered victim always belongs to the lowest-numbered class that holds at least one frame, judged on the bits as they stood at the request edge.
- R7: Within that class the victim is the first member found scanning upward with wraparound from a start index equal to the free-running shift register value modulo the frame count, so repeated requests on an unchanged table spread over several frames.
- R8: `victim_valid` rises in the cycle after the edge that samples `victim_req`, stays high with `victim_idx` unchanged until an edge samples `victim_ack`, and is low in the cycle after that edge.
- R9: While a victim is offered, further requests and any touches or sweeps leave `victim_valid` and `victim_idx` unchanged.
- R10: A fill strobe (`load_valid`) on frame `load_idx` leaves that frame used and clean (class 2); it overrides a touch of the same frame in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_valid | input | 1 | A frame is touched this cycle |
| ref_idx | input | IDX_W | Frame being touched |
| ref_write | input | 1 | The touch is a store |
| clear_tick | input | 1 | Periodic sweep: clear all used bits |
| load_valid | input | 1 | A new page has been installed |
| load_idx | input | IDX_W | Frame receiving the new page |
| victim_req | input | 1 | Ask for a frame to evict |
| victim_ack | input | 1 | Offered victim has been taken |
| victim_valid | output | 1 | `victim_idx` holds an offered victim |
| victim_idx | output | IDX_W | Frame chosen for eviction |

## Verification
The hardest situation to reach is one where the class ordering, and not the random start, decides the answer: with sixteen frames all alike the bench cannot tell a correct pick from a lucky one. The stimulus therefore first stores to every frame but one or two, lifting them to class 3, so that the remaining frames alone set the lowest class and a single frame becomes the only legal victim; the bench then moves that frame between classes with reads, sweeps, a sweep coinciding with a touch, and a fill coinciding with a store, predicting an exact index each time. Spread inside a class is checked separately by repeated requests on an untouched table.

// File: rtl/nru_pkg.sv
package nru_pkg;

    localparam int RNG_W = 16;

    typedef enum logic [1:0] {
        CLS_IDLE_CLEAN = 2'd0,
        CLS_IDLE_DIRTY = 2'd1,
        CLS_USED_CLEAN = 2'd2,
        CLS_USED_DIRTY = 2'd3
    } page_class_e;

    typedef enum logic [0:0] {
        ST_WAIT_REQ = 1'b0,
        ST_OFFER    = 1'b1
    } sel_state_e;

    function automatic page_class_e class_of(input logic used, input logic dirty);
        return page_class_e'({used, dirty});
    endfunction

endpackage

// File: rtl/nru_status_bits.sv
module nru_status_bits #(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_valid,
    input  logic [IDX_W-1:0]      ref_idx,
    input  logic                  ref_write,
    input  logic                  clear_tick,
    input  logic                  load_valid,
    input  logic [IDX_W-1:0]      load_idx,
    output logic [NUM_FRAMES-1:0] used_bits,
    output logic [NUM_FRAMES-1:0] dirty_bits
);

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic hit_touch;
        logic hit_fill;

        assign hit_touch = ref_valid  && (ref_idx  == IDX_W'(f));
        assign hit_fill  = load_valid && (load_idx == IDX_W'(f));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                used_bits[f]  <= 1'b0;
                dirty_bits[f] <= 1'b0;
            end else if (hit_fill) begin
                used_bits[f]  <= 1'b1;
                dirty_bits[f] <= 1'b0;
            end else if (hit_touch) begin
                used_bits[f] <= 1'b1;
                if (ref_write) begin
                    dirty_bits[f] <= 1'b1;
                end
            end else if (clear_tick) begin
                used_bits[f] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr
    import nru_pkg::*;
#(
    parameter logic [RNG_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RNG_W-1:0] rng
);

    logic feedback;

    // Taps 16,14,13,11: maximal-length sequence, never reaches zero from a non-zero seed.
    assign feedback = rng[15] ^ rng[13] ^ rng[12] ^ rng[10];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rng <= SEED;
        end else begin
            rng <= {rng[RNG_W-2:0], feedback};
        end
    end

endmodule

// File: rtl/nru_class_pick.sv
module nru_class_pick
    import nru_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [NUM_FRAMES-1:0] used_bits,
    input  logic [NUM_FRAMES-1:0] dirty_bits,
    input  logic [IDX_W-1:0]      start_idx,
    output logic [IDX_W-1:0]      pick_idx
);

    logic [NUM_FRAMES-1:0] class_mask [4];
    logic [3:0]            class_busy;
    logic [NUM_FRAMES-1:0] member;

    for (genvar c = 0; c < 4; c++) begin : g_class
        for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_member
            assign class_mask[c][f] =
                (class_of(used_bits[f], dirty_bits[f]) == page_class_e'(c));
        end
        assign class_busy[c] = |class_mask[c];
    end

    always_comb begin
        unique casez (class_busy)
            4'b???1: member = class_mask[0];
            4'b??10: member = class_mask[1];
            4'b?100: member = class_mask[2];
            default: member = class_mask[3];
        endcase
    end

    always_comb begin
        logic found;
        int   pos;
        found    = 1'b0;
        pick_idx = start_idx;
        for (int k = 0; k < NUM_FRAMES; k++) begin
            pos = int'(start_idx) + k;
            if (pos >= NUM_FRAMES) begin
                pos = pos - NUM_FRAMES;
            end
            if (!found && member[pos]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter int               NUM_FRAMES = 16,
    parameter logic [RNG_W-1:0] RNG_SEED   = 16'hACE1,
    localparam int              IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic             ref_write,
    input  logic             clear_tick,
    input  logic             load_valid,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             victim_req,
    input  logic             victim_ack,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [RNG_W-1:0] FRAME_COUNT = RNG_W'(NUM_FRAMES);

    logic [NUM_FRAMES-1:0] used_bits;
    logic [NUM_FRAMES-1:0] dirty_bits;
    logic [RNG_W-1:0]      rng;
    logic [IDX_W-1:0]      start_idx;
    logic [IDX_W-1:0]      pick_idx;
    sel_state_e            state_q;
    sel_state_e            state_d;

    nru_status_bits #(.NUM_FRAMES(NUM_FRAMES)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_valid  (ref_valid),
        .ref_idx    (ref_idx),
        .ref_write  (ref_write),
        .clear_tick (clear_tick),
        .load_valid (load_valid),
        .load_idx   (load_idx),
        .used_bits  (used_bits),
        .dirty_bits (dirty_bits)
    );

    nru_lfsr #(.SEED(RNG_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .rng   (rng)
    );

    assign start_idx = IDX_W'(rng % FRAME_COUNT);

    nru_class_pick #(.NUM_FRAMES(NUM_FRAMES)) u_pick (
        .used_bits  (used_bits),
        .dirty_bits (dirty_bits),
        .start_idx  (start_idx),
        .pick_idx   (pick_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_REQ: if (victim_req) state_d = ST_OFFER;
            ST_OFFER:    if (victim_ack) state_d = ST_WAIT_REQ;
            default:     state_d = ST_WAIT_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_REQ;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_idx <= '0;
        end else if (state_q == ST_WAIT_REQ && victim_req) begin
            victim_idx <= pick_idx;
        end
    end

    assign victim_valid = (state_q == ST_OFFER);

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
    parameter int NUM_FRAMES = 16,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ref_valid,
    input logic [IDX_W-1:0]      ref_idx,
    input logic                  ref_write,
    input logic                  clear_tick,
    input logic                  load_valid,
    input logic [IDX_W-1:0]      load_idx,
    input logic                  victim_req,
    input logic                  victim_ack,
    input logic                  victim_valid,
    input logic [IDX_W-1:0]      victim_idx,
    input logic [NUM_FRAMES-1:0] used_bits,
    input logic [NUM_FRAMES-1:0] dirty_bits
);

    // Independent view of the lowest occupied class, one cycle delayed.
    logic [NUM_FRAMES-1:0] legal_now;
    logic [NUM_FRAMES-1:0] legal_q;

    always_comb begin
        int lowest;
        lowest = 3;
        for (int f = 0; f < NUM_FRAMES; f++) begin
            if (2 * int'(used_bits[f]) + int'(dirty_bits[f]) < lowest) begin
                lowest = 2 * int'(used_bits[f]) + int'(dirty_bits[f]);
            end
        end
        for (int f = 0; f < NUM_FRAMES; f++) begin
            legal_now[f] = (2 * int'(used_bits[f]) + int'(dirty_bits[f]) == lowest);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) legal_q <= '0;
        else        legal_q <= legal_now;
    end

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (used_bits == '0 && dirty_bits == '0 && !victim_valid));

    assert_touch_sets_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> used_bits[$past(ref_idx)]);

    assert_store_sets_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_write && !(load_valid && load_idx == ref_idx))
        |=> dirty_bits[$past(ref_idx)]);

    assert_sweep_clears_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_tick && !ref_valid && !load_valid) |=> (used_bits == '0));

    assert_sweep_keeps_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_tick && !ref_valid && !load_valid) |=> (dirty_bits == $past(dirty_bits)));

    assert_touch_beats_sweep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_tick && ref_valid) |=> ($countones(used_bits) >= 1 && used_bits[$past(ref_idx)]));

    assert_lowest_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(victim_valid) |-> legal_q[victim_idx]);

    assert_offer_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!victim_valid && victim_req) |=> victim_valid);

    assert_offer_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !victim_ack) |=> (victim_valid && $stable(victim_idx)));

    assert_offer_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && victim_ack) |=> !victim_valid);

    assert_fill_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> (used_bits[$past(load_idx)] && !dirty_bits[$past(load_idx)]));

endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .ref_idx      (ref_idx),
    .ref_write    (ref_write),
    .clear_tick   (clear_tick),
    .load_valid   (load_valid),
    .load_idx     (load_idx),
    .victim_req   (victim_req),
    .victim_ack   (victim_ack),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx),
    .used_bits    (used_bits),
    .dirty_bits   (dirty_bits)
);

// File: tb/test_nru_victim_sel.sv
`timescale 1ns/1ps
module test_nru_victim_sel;

    localparam int NF   = 16;
    localparam int IW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          ref_write = 1'b0;
    logic          clear_tick = 1'b0;
    logic          load_valid = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic          victim_req = 1'b0;
    logic          victim_ack = 1'b0;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit m_used  [NF];
    bit m_dirty [NF];

    logic [NF-1:0] exp_q [$];
    string         tag_q [$];
    bit            mon_prev = 1'b0;

    always #2.5 clk = ~clk;

    nru_victim_sel #(.NUM_FRAMES(NF)) i_nru_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_idx      (ref_idx),
        .ref_write    (ref_write),
        .clear_tick   (clear_tick),
        .load_valid   (load_valid),
        .load_idx     (load_idx),
        .victim_req   (victim_req),
        .victim_ack   (victim_ack),
        .victim_valid (victim_valid),
        .victim_idx   (victim_idx)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] legal_mask();
        int lowest = 3;
        logic [NF-1:0] m;
        for (int f = 0; f < NF; f++)
            if (2 * int'(m_used[f]) + int'(m_dirty[f]) < lowest)
                lowest = 2 * int'(m_used[f]) + int'(m_dirty[f]);
        for (int f = 0; f < NF; f++)
            m[f] = (2 * int'(m_used[f]) + int'(m_dirty[f]) == lowest);
        return m;
    endfunction

    // Monitor: pop the expected legal set on each new offer.
    always @(negedge clk) begin
        if (rst_n && victim_valid && !mon_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected offer", int'(victim_idx), 0);
            end else begin
                logic [NF-1:0] m;
                string t;
                m = exp_q.pop_front();
                t = tag_q.pop_front();
                check(m[victim_idx], t, "victim outside lowest class (exp=mask)",
                      int'(victim_idx), int'(m));
            end
        end
        mon_prev = victim_valid;
    end

    task automatic touch(input int idx, input bit wr, input bit sweep);
        @(negedge clk);
        ref_valid = 1'b1; ref_idx = IW'(idx); ref_write = wr; clear_tick = sweep;
        @(negedge clk);
        ref_valid = 1'b0; ref_write = 1'b0; clear_tick = 1'b0;
        if (sweep) for (int f = 0; f < NF; f++) m_used[f] = 1'b0;
        m_used[idx] = 1'b1;
        if (wr) m_dirty[idx] = 1'b1;
    endtask

    task automatic sweep();
        @(negedge clk);
        clear_tick = 1'b1;
        @(negedge clk);
        clear_tick = 1'b0;
        for (int f = 0; f < NF; f++) m_used[f] = 1'b0;
    endtask

    task automatic fill_with_store(input int idx);
        @(negedge clk);
        load_valid = 1'b1; load_idx = IW'(idx);
        ref_valid = 1'b1; ref_idx = IW'(idx); ref_write = 1'b1;
        @(negedge clk);
        load_valid = 1'b0; ref_valid = 1'b0; ref_write = 1'b0;
        m_used[idx] = 1'b1; m_dirty[idx] = 1'b0;
    endtask

    task automatic request(input string tag, output int got);
        exp_q.push_back(legal_mask());
        tag_q.push_back(tag);
        @(negedge clk);
        victim_req = 1'b1;
        @(negedge clk);
        victim_req = 1'b0;
        check(victim_valid === 1'b1, "R8", "valid one cycle after request", int'(victim_valid), 1);
        got = int'(victim_idx);
    endtask

    task automatic acknowledge();
        @(negedge clk);
        victim_ack = 1'b1;
        @(negedge clk);
        victim_ack = 1'b0;
        check(victim_valid === 1'b0, "R8", "valid low after ack", int'(victim_valid), 0);
    endtask

    task automatic expect_exact(input string tag, input int want);
        int got;
        request(tag, got);
        check(got == want, tag, "exact victim", got, want);
        acknowledge();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int got;
        logic [NF-1:0] seen;
        for (int f = 0; f < NF; f++) begin m_used[f] = 1'b0; m_dirty[f] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(victim_valid === 1'b0, "R1", "valid after reset", int'(victim_valid), 0);

        // R7: untouched table, repeated requests spread over frames
        seen = '0;
        for (int n = 0; n < 8; n++) begin
            request("R7", got);
            seen[got] = 1'b1;
            acknowledge();
            repeat (n + 1) @(negedge clk);
        end
        check($countones(seen) >= 2, "R7", "distinct victims", $countones(seen), 2);

        // R2/R3/R6: lift all but frames 5 and 9 to class 3
        for (int f = 0; f < NF; f++) if (f != 5 && f != 9) touch(f, 1'b1, 1'b0);
        request("R6", got);
        check(got == 5 || got == 9, "R6", "victim among two class-0 frames", got, 5);
        acknowledge();
        touch(9, 1'b0, 1'b0);                  // 9 -> class 2 (read keeps dirty 0)
        expect_exact("R2", 5);
        touch(5, 1'b1, 1'b0);                  // 5 -> class 3, 9 class 2
        expect_exact("R3", 9);

        // R4: sweep clears used, keeps dirty: 9 class 0, rest class 1
        sweep();
        expect_exact("R4", 9);

        // R5: sweep together with read of 9 keeps 9 used (class 2)
        touch(9, 1'b0, 1'b0);
        touch(9, 1'b0, 1'b1);
        request("R5", got);
        check(got != 9, "R5", "touched frame not in lowest class", got, 0);
        acknowledge();

        // R9: offer stays put through requests, touches and sweeps
        request("R9", got);
        @(negedge clk);
        victim_req = 1'b1; ref_valid = 1'b1; ref_idx = IW'(got); ref_write = 1'b1; clear_tick = 1'b1;
        @(negedge clk);
        victim_req = 1'b0; ref_valid = 1'b0; ref_write = 1'b0; clear_tick = 1'b0;
        for (int f = 0; f < NF; f++) m_used[f] = 1'b0;
        m_used[got] = 1'b1; m_dirty[got] = 1'b1;
        check(victim_valid === 1'b1, "R9", "still valid", int'(victim_valid), 1);
        check(int'(victim_idx) == got, "R9", "index held", int'(victim_idx), got);
        acknowledge();

        // R10: store to all, then fill+store on 4 in one cycle -> 4 class 2
        for (int f = 0; f < NF; f++) touch(f, 1'b1, 1'b0);
        fill_with_store(4);
        expect_exact("R10", 4);
        sweep();                                // 4 -> class 0, rest class 1
        expect_exact("R10", 4);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule